// File: doc/BRIEF.md
# AES-128 Block Mover with CBC Chaining

This block is the control front end of a memory-mapped AES-128 accelerator. Software programs a source address, a destination address, a 128-bit key and a 128-bit initial chaining value through 32-bit register writes. It then issues one control word that carries the direction, the number of blocks and whether to resume the previous chain. The sequencer fetches each 16-byte block over a word-wide memory master port and passes it to an external single-block cipher through a start/done handshake. It applies cipher-block chaining around that cipher and writes the result back to memory.

Software polls the busy bit in the control word until it clears, and also checks the error bit. A one-cycle completion pulse is available when enabled. Writing zero to the control word stops any activity at once. The round logic and the key schedule sit outside this block.

Top module: `aes_dma_seq`

## Requirements
- R1: After reset the control word reads 0, no memory request is raised and the completion pulse is low.
- R2: Four successive writes to offset 0x0C load the key, first write into bits 127:96 and last into bits 31:0. The key appears unchanged on `cph_key` and is used by the cipher. Offset 0x10 loads the initial chaining value in the same way.
- R3: A control write (offset 0x00) with bit 31 set starts a command of (bits 11:0)+1 blocks. Bit 27 selects decrypt, bit 30 enables the completion pulse and bit 28 is stored as an enable flag. Bit 31 reads 1 while the command runs and 0 once the last block has been written.
- R4: Each block is read as four 32-bit words at increasing addresses starting at the source address, and written as four words starting at the destination address. The word at the lowest address is block bits 127:96. Nothing past the last block is written.
- R5: Encrypt: the plaintext is XORed with the chaining value before the cipher, and the cipher output is both the result and the next chaining value.
- R6: Decrypt: the cipher output is XORed with the chaining value to give the result, and the input ciphertext becomes the next chaining value.
- R7: With control bit 12 set, chaining resumes from the value left by the previous command and the loaded chaining register is ignored. With bit 12 clear, it starts from the loaded value.
- R8: Writing 0 to the control word aborts at once. The control word then reads 0 and no further memory requests occur.
- R9: Starting with a source or destination address that is not a multiple of 16 sets bit 29, leaves bit 31 clear and makes no memory request.
- R10: When bit 30 was set, `irq` is high for exactly one cycle when a command completes. It stays low when bit 30 was clear.
- R11: A nonzero control write while a command runs is ignored. The command and the fields it reads back are unchanged.
- R12: Source and destination may be the same buffer, and the result is the same as with separate buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (control, source, destination; others read 0) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |
| cph_start | output | 1 | One-cycle cipher start |
| cph_decrypt | output | 1 | Cipher direction |
| cph_key | output | 128 | Cipher key |
| cph_din | output | 128 | Cipher input block |
| cph_done | input | 1 | Cipher result valid |
| cph_dout | input | 128 | Cipher result |
| irq | output | 1 | Completion pulse |

## Verification
A register write can arrive in the same cycle as the engine's own state change, and two such collisions are provoked. In the first, a nonzero control word is written while a command is stalled on memory or waiting for the cipher. The bench then judges that the command's data and its read-back count and direction are those of the first command. In the second, a zero control write lands mid-transfer. The control word must read 0 and the memory request counter must stay frozen, even though a late cipher completion still arrives. The sweeps run every block count from 1 to 4, both directions and both in-place and separate buffers under a rotating acknowledge stall pattern, and the expected chaining is computed in the bench.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;
    localparam int WORD_W        = 32;
    localparam int BLK_W         = 128;
    localparam int WORDS_PER_BLK = BLK_W / WORD_W;
    localparam int BLK_BYTES     = BLK_W / 8;

    localparam logic [4:0] OFF_CTRL = 5'h00;
    localparam logic [4:0] OFF_SRC  = 5'h04;
    localparam logic [4:0] OFF_DST  = 5'h08;
    localparam logic [4:0] OFF_KEY  = 5'h0C;
    localparam logic [4:0] OFF_IV   = 5'h10;

    localparam int BIT_RUN  = 31;
    localparam int BIT_IE   = 30;
    localparam int BIT_ERR  = 29;
    localparam int BIT_ENA  = 28;
    localparam int BIT_DEC  = 27;
    localparam int BIT_KEEP = 12;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_CIPH  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;
endpackage

// File: rtl/aes_seq_wordload.sv
module aes_seq_wordload #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [WORD_W-1:0]        word_i,
    output logic [WORD_W*NWORDS-1:0] value_o
);
    localparam int VAL_W = WORD_W * NWORDS;

    logic [VAL_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load_i) begin
            val_d = {val_q[VAL_W-WORD_W-1:0], word_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value_o = val_q;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(value_o));

    // R2
    newest_word_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (value_o[WORD_W-1:0] == $past(word_i)));
endmodule

// File: rtl/aes_seq_engine.sv
module aes_seq_engine
    import aes_seq_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we_i,
    input  logic              src_we_i,
    input  logic              dst_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BLK_W-1:0]  key_i,
    input  logic [BLK_W-1:0]  iv_i,
    output logic [WORD_W-1:0] ctrl_o,
    output logic [AW-1:0]     src_o,
    output logic [AW-1:0]     dst_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              cph_start_o,
    output logic              cph_decrypt_o,
    output logic [BLK_W-1:0]  cph_key_o,
    output logic [BLK_W-1:0]  cph_din_o,
    input  logic              cph_done_i,
    input  logic [BLK_W-1:0]  cph_dout_i,
    output logic              irq_o
);
    localparam int WIDX_W     = $clog2(WORDS_PER_BLK);
    localparam int ALIGN_BITS = $clog2(BLK_BYTES);
    localparam int WBYTES     = WORD_W / 8;
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS_PER_BLK - 1);

    typedef struct packed {
        phase_e              phase;
        logic                run;
        logic                ie;
        logic                err;
        logic                ena;
        logic                dec;
        logic                keep;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    left;
        logic [WIDX_W-1:0]   widx;
        logic [AW-1:0]       src;
        logic [AW-1:0]       dst;
        logic [AW-1:0]       rptr;
        logic [AW-1:0]       wptr;
        logic [BLK_W-1:0]    blk;
        logic [BLK_W-1:0]    chain;
        logic [BLK_W-1:0]    res;
        logic                irq;
        logic                cstart;
    } eng_t;

    eng_t eng_d, eng_q;
    logic misaligned;

    assign misaligned = (eng_q.src[ALIGN_BITS-1:0] != '0) ||
                        (eng_q.dst[ALIGN_BITS-1:0] != '0);

    always_comb begin
        eng_d        = eng_q;
        eng_d.irq    = 1'b0;
        eng_d.cstart = 1'b0;
        if (src_we_i) eng_d.src = wdata_i;
        if (dst_we_i) eng_d.dst = wdata_i;

        if (ctrl_we_i && (wdata_i == '0)) begin
            eng_d.phase = PH_IDLE;
            eng_d.run   = 1'b0;
            eng_d.ie    = 1'b0;
            eng_d.err   = 1'b0;
            eng_d.ena   = 1'b0;
            eng_d.dec   = 1'b0;
            eng_d.keep  = 1'b0;
            eng_d.cnt   = '0;
        end else if (ctrl_we_i && (eng_q.phase == PH_IDLE)) begin
            eng_d.ie   = wdata_i[BIT_IE];
            eng_d.ena  = wdata_i[BIT_ENA];
            eng_d.dec  = wdata_i[BIT_DEC];
            eng_d.keep = wdata_i[BIT_KEEP];
            eng_d.cnt  = wdata_i[CNT_W-1:0];
            eng_d.err  = 1'b0;
            if (wdata_i[BIT_RUN]) begin
                if (misaligned) begin
                    eng_d.err = 1'b1;
                end else begin
                    eng_d.run   = 1'b1;
                    eng_d.phase = PH_READ;
                    eng_d.widx  = '0;
                    eng_d.rptr  = eng_q.src;
                    eng_d.wptr  = eng_q.dst;
                    eng_d.left  = wdata_i[CNT_W-1:0];
                    eng_d.chain = wdata_i[BIT_KEEP] ? eng_q.chain : iv_i;
                end
            end
        end else begin
            unique case (eng_q.phase)
                PH_READ: begin
                    if (mem_ack_i) begin
                        eng_d.blk  = {eng_q.blk[BLK_W-WORD_W-1:0], mem_rdata_i};
                        eng_d.rptr = eng_q.rptr + AW'(WBYTES);
                        eng_d.widx = eng_q.widx + 1'b1;
                        if (eng_q.widx == LAST_WORD) begin
                            eng_d.phase  = PH_CIPH;
                            eng_d.cstart = 1'b1;
                        end
                    end
                end
                PH_CIPH: begin
                    if (cph_done_i) begin
                        eng_d.phase = PH_WRITE;
                        eng_d.widx  = '0;
                        if (eng_q.dec) begin
                            eng_d.res   = cph_dout_i ^ eng_q.chain;
                            eng_d.chain = eng_q.blk;
                        end else begin
                            eng_d.res   = cph_dout_i;
                            eng_d.chain = cph_dout_i;
                        end
                    end
                end
                PH_WRITE: begin
                    if (mem_ack_i) begin
                        eng_d.res  = {eng_q.res[BLK_W-WORD_W-1:0], {WORD_W{1'b0}}};
                        eng_d.wptr = eng_q.wptr + AW'(WBYTES);
                        eng_d.widx = eng_q.widx + 1'b1;
                        if (eng_q.widx == LAST_WORD) begin
                            eng_d.widx = '0;
                            if (eng_q.left == '0) begin
                                eng_d.phase = PH_IDLE;
                                eng_d.run   = 1'b0;
                                eng_d.irq   = eng_q.ie;
                            end else begin
                                eng_d.left  = eng_q.left - 1'b1;
                                eng_d.phase = PH_READ;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.phase <= PH_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        ctrl_o           = '0;
        ctrl_o[BIT_RUN]  = eng_q.run;
        ctrl_o[BIT_IE]   = eng_q.ie;
        ctrl_o[BIT_ERR]  = eng_q.err;
        ctrl_o[BIT_ENA]  = eng_q.ena;
        ctrl_o[BIT_DEC]  = eng_q.dec;
        ctrl_o[BIT_KEEP] = eng_q.keep;
        ctrl_o[CNT_W-1:0] = eng_q.cnt;
    end

    assign src_o         = eng_q.src;
    assign dst_o         = eng_q.dst;
    assign mem_req_o     = (eng_q.phase == PH_READ) || (eng_q.phase == PH_WRITE);
    assign mem_we_o      = (eng_q.phase == PH_WRITE);
    assign mem_addr_o    = (eng_q.phase == PH_WRITE) ? eng_q.wptr : eng_q.rptr;
    assign mem_wdata_o   = eng_q.res[BLK_W-1 -: WORD_W];
    assign cph_start_o   = eng_q.cstart;
    assign cph_decrypt_o = eng_q.dec;
    assign cph_key_o     = key_i;
    assign cph_din_o     = eng_q.dec ? eng_q.blk : (eng_q.blk ^ eng_q.chain);
    assign irq_o         = eng_q.irq;

    // R3
    mem_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ctrl_o[BIT_RUN]);

    // R4
    word_aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R5
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start_o |=> !cph_start_o);

    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && (wdata_i == '0)) |=> ((ctrl_o == '0) && !mem_req_o));

    // R9
    misalign_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_o[BIT_ERR]) |-> (!ctrl_o[BIT_RUN] && !mem_req_o));

    // R10
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10
    irq_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $fell(ctrl_o[BIT_RUN]));

    // R11
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && (wdata_i != '0) && ctrl_o[BIT_RUN]) |=> $stable(ctrl_o[CNT_W-1:0]));
endmodule

// File: rtl/aes_dma_seq.sv
module aes_dma_seq
    import aes_seq_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         mem_req,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    input  logic         mem_ack,
    input  logic [31:0]  mem_rdata,
    output logic         cph_start,
    output logic         cph_decrypt,
    output logic [127:0] cph_key,
    output logic [127:0] cph_din,
    input  logic         cph_done,
    input  logic [127:0] cph_dout,
    output logic         irq
);
    localparam int NLOAD = 2;

    logic [NLOAD-1:0] load_we;
    logic [BLK_W-1:0] load_val [NLOAD];
    logic [31:0]      ctrl_word, src_word, dst_word;

    assign load_we[0] = reg_wr && (reg_addr == OFF_KEY);
    assign load_we[1] = reg_wr && (reg_addr == OFF_IV);

    for (genvar g = 0; g < NLOAD; g++) begin : g_load
        aes_seq_wordload #(.WORD_W(WORD_W), .NWORDS(WORDS_PER_BLK)) u_load (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_we[g]),
            .word_i  (reg_wdata),
            .value_o (load_val[g])
        );
    end

    aes_seq_engine #(.CNT_W(CNT_W), .AW(32)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we_i     (reg_wr && (reg_addr == OFF_CTRL)),
        .src_we_i      (reg_wr && (reg_addr == OFF_SRC)),
        .dst_we_i      (reg_wr && (reg_addr == OFF_DST)),
        .wdata_i       (reg_wdata),
        .key_i         (load_val[0]),
        .iv_i          (load_val[1]),
        .ctrl_o        (ctrl_word),
        .src_o         (src_word),
        .dst_o         (dst_word),
        .mem_req_o     (mem_req),
        .mem_we_o      (mem_we),
        .mem_addr_o    (mem_addr),
        .mem_wdata_o   (mem_wdata),
        .mem_ack_i     (mem_ack),
        .mem_rdata_i   (mem_rdata),
        .cph_start_o   (cph_start),
        .cph_decrypt_o (cph_decrypt),
        .cph_key_o     (cph_key),
        .cph_din_o     (cph_din),
        .cph_done_i    (cph_done),
        .cph_dout_i    (cph_dout),
        .irq_o         (irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = ctrl_word;
            OFF_SRC:  reg_rdata = src_word;
            OFF_DST:  reg_rdata = dst_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/tb_aes_dma_seq.sv
module tb_aes_dma_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   reg_addr = 5'h00;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr, mem_wdata, mem_rdata;
    logic         cph_start, cph_decrypt;
    logic [127:0] cph_key, cph_din;
    logic         cph_done = 1'b0;
    logic [127:0] cph_dout = '0;
    logic         irq;

    int checks = 0;
    int failures = 0;
    int unsigned cyc = 0;
    int unsigned mreq_cnt = 0;
    int unsigned irq_cnt = 0;
    logic [7:0]  stall_pat = 8'hFF;

    logic [31:0] mem [0:255];
    logic [31:0] img [0:255];
    logic        fill_we = 1'b0;
    logic [7:0]  fill_idx = '0;
    logic [31:0] fill_val = '0;

    logic [127:0] key_ref, iv_ref, chain_ref;
    logic [31:0]  exp_w [0:63];

    always #5 clk = ~clk;

    aes_dma_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cph_start(cph_start),
        .cph_decrypt(cph_decrypt), .cph_key(cph_key), .cph_din(cph_din),
        .cph_done(cph_done), .cph_dout(cph_dout), .irq(irq)
    );

    assign mem_ack   = mem_req && stall_pat[cyc[2:0]];
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) mreq_cnt <= mreq_cnt + 1;
        if (irq)     irq_cnt  <= irq_cnt + 1;
        if (fill_we) mem[fill_idx] <= fill_val;
        else if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
        if (cyc > 150000) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog expired: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [127:0] f_enc(logic [127:0] x, logic [127:0] k);
        return {x[126:0], x[127]} ^ k;
    endfunction
    function automatic logic [127:0] f_dec(logic [127:0] x, logic [127:0] k);
        logic [127:0] y;
        y = x ^ k;
        return {y[0], y[127:1]};
    endfunction

    // cipher stub: three-cycle latency
    logic [127:0] stub_v = '0;
    logic         stub_pend = 1'b0;
    int           stub_lat = 0;
    always @(negedge clk) begin
        cph_done = 1'b0;
        if (cph_start) begin
            stub_v    = cph_decrypt ? f_dec(cph_din, cph_key) : f_enc(cph_din, cph_key);
            stub_pend = 1'b1;
            stub_lat  = 2;
        end else if (stub_pend) begin
            if (stub_lat == 0) begin
                cph_done  = 1'b1;
                cph_dout  = stub_v;
                stub_pend = 1'b0;
            end else begin
                stub_lat = stub_lat - 1;
            end
        end
    end

    task automatic check32(string req, logic [31:0] got, logic [31:0] expv);
        checks = checks + 1;
        if (got !== expv) begin
            failures = failures + 1;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic reg_write(logic [4:0] a, logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'h00;
    endtask

    task automatic load128(logic [4:0] a, logic [127:0] v);
        for (int i = 0; i < 4; i++) reg_write(a, v[127 - 32*i -: 32]);
    endtask

    task automatic fill(int idx, logic [31:0] v);
        fill_idx = 8'(idx); fill_val = v; fill_we = 1'b1;
        img[idx] = v;
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic fill_src(int sbyte, int n, int seed);
        for (int i = 0; i < n * 4; i++)
            fill(sbyte / 4 + i, (32'h9E37_79B9 * (i + 1 + seed * 7)) ^ 32'(seed << 20));
    endtask

    task automatic calc(int sbyte, int n, bit dec, bit keep);
        logic [127:0] b, o;
        if (!keep) chain_ref = iv_ref;
        for (int k = 0; k < n; k++) begin
            b = {img[sbyte/4 + 4*k], img[sbyte/4 + 4*k + 1],
                 img[sbyte/4 + 4*k + 2], img[sbyte/4 + 4*k + 3]};
            if (!dec) begin
                o = f_enc(b ^ chain_ref, key_ref);
                chain_ref = o;
            end else begin
                o = f_dec(b, key_ref) ^ chain_ref;
                chain_ref = b;
            end
            for (int j = 0; j < 4; j++) exp_w[4*k + j] = o[127 - 32*j -: 32];
        end
    endtask

    function automatic logic [31:0] ctrl_of(int n, bit dec, bit keep, bit ie);
        logic [31:0] c;
        c = 32'h9000_0000;
        c[30] = ie; c[27] = dec; c[12] = keep;
        c[11:0] = 12'(n - 1);
        return c;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            if (!reg_rdata[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(int s, int d, int n, bit dec, bit keep, bit ie);
        reg_write(5'h04, 32'(s));
        reg_write(5'h08, 32'(d));
        reg_write(5'h00, ctrl_of(n, dec, keep, ie));
        wait_idle();
        @(negedge clk);
    endtask

    task automatic check_out(string req, int d, int n);
        for (int i = 0; i < n * 4; i++) check32(req, mem[d/4 + i], exp_w[i]);
    endtask

    initial begin
        int irq0, m0;
        for (int i = 0; i < 256; i++) img[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check32("R1 ctrl", reg_rdata, 32'h0);
        check32("R1 req_irq", {30'h0, mem_req, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 ctrl after release", reg_rdata, 32'h0);

        key_ref = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
        iv_ref  = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
        load128(5'h0C, key_ref);
        load128(5'h10, iv_ref);
        // R2 key word order
        check32("R2 key hi", cph_key[127:96], key_ref[127:96]);
        check32("R2 key lo", cph_key[31:0], key_ref[31:0]);
        reg_addr = 5'h04; reg_wdata = 32'h1234_5670; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        check32("R3 src readback", reg_rdata, 32'h1234_5670);
        reg_addr = 5'h00;

        // sweep: direction x block count x buffer placement x stall pattern
        for (int dec = 0; dec < 2; dec++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int inp = 0; inp < 2; inp++) begin
                    int d;
                    d = inp ? 32'h100 : 32'h200;
                    stall_pat = (n == 1) ? 8'hFF : (n == 2) ? 8'b1011_0110 :
                                (n == 3) ? 8'b0101_0101 : 8'b1110_0011;
                    fill_src(32'h100, n, dec * 8 + n * 2 + inp);
                    fill(d/4 + n*4, 32'hDEAD_0000 | 32'(n));
                    calc(32'h100, n, dec[0], 1'b0);
                    irq0 = irq_cnt;
                    reg_write(5'h04, 32'h100);
                    reg_write(5'h08, 32'(d));
                    reg_write(5'h00, ctrl_of(n, dec[0], 1'b0, n[0]));
                    check32("R3 busy bit set", {31'h0, reg_rdata[31]}, 32'h1);
                    wait_idle();
                    @(negedge clk);
                    if (dec == 0) check_out(inp ? "R5 R12 enc in place" : "R5 enc", d, n);
                    else          check_out(inp ? "R6 R12 dec in place" : "R6 dec", d, n);
                    check32("R4 no write past end", mem[d/4 + n*4], 32'hDEAD_0000 | 32'(n));
                    check32("R3 readback", reg_rdata,
                            ctrl_of(n, dec[0], 1'b0, n[0]) & 32'h7FFF_FFFF);
                    check32("R10 irq pulse count", 32'(irq_cnt - irq0), 32'(n[0]));
                end
            end
        end
        stall_pat = 8'b1101_1011;

        // R7 resume chain, loaded IV ignored
        for (int dec = 0; dec < 2; dec++) begin
            load128(5'h10, iv_ref);
            fill_src(32'h100, 4, 40 + dec);
            calc(32'h100, 2, dec[0], 1'b0);
            run_cmd(32'h100, 32'h200, 2, dec[0], 1'b0, 1'b0);
            check_out("R7 first half", 32'h200, 2);
            load128(5'h10, 128'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_5555);
            calc(32'h120, 2, dec[0], 1'b1);
            run_cmd(32'h120, 32'h220, 2, dec[0], 1'b1, 1'b0);
            check_out("R7 resumed half", 32'h220, 2);
        end
        iv_ref = 128'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_5555;

        // R11 control write during a running command
        fill_src(32'h100, 2, 50);
        calc(32'h100, 2, 1'b0, 1'b0);
        reg_write(5'h04, 32'h100);
        reg_write(5'h08, 32'h200);
        reg_write(5'h00, ctrl_of(2, 1'b0, 1'b0, 1'b0));
        repeat (4) @(negedge clk);
        reg_write(5'h00, 32'h8800_0005);
        wait_idle();
        @(negedge clk);
        check_out("R11 data unchanged", 32'h200, 2);
        check32("R11 fields unchanged", reg_rdata & 32'h0800_0FFF, 32'h0000_0001);

        // R8 abort mid-command
        fill_src(32'h100, 4, 60);
        irq0 = irq_cnt;
        reg_write(5'h00, ctrl_of(4, 1'b0, 1'b0, 1'b1));
        repeat (9) @(negedge clk);
        reg_write(5'h00, 32'h0);
        check32("R8 ctrl zero", reg_rdata, 32'h0);
        m0 = mreq_cnt;
        repeat (40) @(negedge clk);
        check32("R8 no further requests", 32'(mreq_cnt - m0), 32'h0);
        check32("R8 R10 no irq after abort", 32'(irq_cnt - irq0), 32'h0);

        // R9 misaligned source and destination
        m0 = mreq_cnt;
        reg_write(5'h04, 32'h104);
        reg_write(5'h08, 32'h200);
        reg_write(5'h00, ctrl_of(1, 1'b0, 1'b0, 1'b0));
        check32("R9 err set run clear", reg_rdata & 32'hA000_0000, 32'h2000_0000);
        reg_write(5'h04, 32'h100);
        reg_write(5'h08, 32'h208);
        reg_write(5'h00, ctrl_of(1, 1'b1, 1'b0, 1'b0));
        repeat (5) @(negedge clk);
        check32("R9 dst err", reg_rdata & 32'hA000_0000, 32'h2000_0000);
        check32("R9 no access", 32'(mreq_cnt - m0), 32'h0);

        // recovery after error with a fresh chain
        fill_src(32'h100, 3, 70);
        calc(32'h100, 3, 1'b1, 1'b0);
        run_cmd(32'h100, 32'h200, 3, 1'b1, 1'b0, 1'b0);
        check_out("R6 after error", 32'h200, 3);
        check32("R9 err cleared by new command", {31'h0, reg_rdata[29]}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule